// File: doc/BRIEF.md
# Frame Column Window Mapper

This block places a byte stream into the payload bit slots of a serial bus frame built from rows and columns, and collects a second byte stream from the slots that the far end drives. It follows its own row and column position from reset. The frame size is set by a column count and a row count. A window is set by a start column, a stop column, a sample interval and a word length. Column 0 always belongs to the command channel. Command traffic there runs on while bulk data fills the other columns.

In every bus clock the block tells whether the current slot belongs to the bulk window. It also tells whether that slot carries data or padding. For data, it either drives the next transmit bit or captures a receive bit. A per-slot direction input picks which of the two. Bytes go out MSB first, across the window slots from left to right, one row after another. A byte may cross a row boundary and carry on in the next row. The data slots in each frame are a whole number of bytes. The window-slot count of the previous frame sets how many slots this frame uses for data, and the tail that is left over is padding.

A typical full-frame setting for N columns is start column 1, stop column N-1, sample interval N and word length N-1. Other settings open a narrower window or one that repeats inside a row.

Top module: `frame_window_mapper`

## Requirements
- R1: A slot in column 0 is never part of the window: `win_active` and `bus_oe` are low there.
- R2: `config_error` is high whenever the start column is 0, or the stop column is below the start column, or the stop column is at least the column count. While it is high, `win_active`, `win_pad`, `bus_oe` and `tx_req` stay low.
- R3: The position starts at row 0, column 0 after reset. Columns run from 0 to cols-1, then the row advances, and the row wraps after rows-1. An offset counts slots from the frame start and wraps to 0 when it reaches the interval. A slot is in the window (`win_active`=1) when its column is not 0, its offset lies between start and stop inclusive, and offset-start is below the word length.
- R4: Data bits go out MSB first in slot order. `tx_req` is high in the slot that carries bit 7 of a new byte. `tx_byte` is sampled in that cycle, and its bit 7 appears on `bus_dout` in the same cycle. The following transmit data slots carry bits 6 down to 0.
- R5: A byte that is not complete at the end of a row carries on in the next window slot of the following row.
- R6: Let W be the window-slot count of the previous frame. In the current frame, window slots with index below 8*floor(W/8) are data, and the rest are padding (`win_pad`=1). A padding slot takes no byte. It drives 0 with `bus_oe` high when `slot_rx`=0, and it captures nothing when `slot_rx`=1.
- R7: In the first frame after reset, every window slot is padding.
- R8: A data slot with `slot_rx`=1 leaves `bus_oe` low and shifts `bus_din` in, MSB first. The cycle after the 8th captured bit, `rx_valid` is high for one cycle with the byte on `rx_byte`.
- R9: During reset, `bus_oe`, `tx_req`, `rx_valid`, `win_active` and `win_pad` are low.
- R10: The transmit and receive streams keep separate bit counts. A receive data slot never raises `tx_req` and does not advance the transmit byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock, one slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cols | input | COL_W | Columns per row (N) |
| cfg_rows | input | ROW_W | Rows per frame |
| cfg_start | input | COL_W | First offset of the window |
| cfg_stop | input | COL_W | Last offset of the window |
| cfg_interval | input | COL_W+ROW_W | Slots between window repeats |
| cfg_wordlen | input | COL_W | Slots used from each window repeat |
| slot_rx | input | 1 | Current slot is driven by the far end |
| bus_din | input | 1 | Bit sampled from the bus |
| tx_byte | input | 8 | Next transmit byte, taken when tx_req is high |
| tx_req | output | 1 | Transmit byte consumed this cycle |
| bus_dout | output | 1 | Bit driven onto the bus |
| bus_oe | output | 1 | Block drives the bus in this slot |
| rx_byte | output | 8 | Assembled receive byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| win_active | output | 1 | Current slot is in the bulk window |
| win_pad | output | 1 | Current window slot is padding |
| config_error | output | 1 | Window settings are not allowed |

## Verification
The mapper is run with a full-frame window whose slot count is not a multiple of eight, so that both the padding tail and bytes that cross rows show up. A narrow window that is two columns wide checks the start, stop and word-length limits apart from the column count. A window whose interval is shorter than a row checks that the offset wraps apart from the column. Direction patterns of all transmit, alternate rows, a checkerboard and a single receive column split the two streams, so that a shared bit count or a swapped bit order would fail. Three bad settings, one for each rule, each have to raise the error flag and keep the bus quiet.

// File: rtl/fwm_pkg.sv
// Shared types for the frame column window mapper.
// Assumes: one bus slot per clock, and the slot classification is the same in every sub-block.
package fwm_pkg;
    typedef enum logic [1:0] {
        SLOT_OFF = 2'd0,   // outside the bulk window
        SLOT_PAD = 2'd1,   // window slot that is padding
        SLOT_TX  = 2'd2,   // window data slot that the block drives
        SLOT_RX  = 2'd3    // window data slot that the far end drives
    } slot_kind_e;
endpackage

// File: rtl/fwm_position.sv
// Follows the row, column and interval offset of the current bus slot.
// Assumes: the frame layout is static between resets, and position 0/0 follows reset.
module fwm_position #(
    parameter int COL_W  = 5,
    parameter int ROW_W  = 6,
    parameter int SLOT_W = COL_W + ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  cfg_cols,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [SLOT_W-1:0] cfg_interval,
    output logic [COL_W-1:0]  col,
    output logic [ROW_W-1:0]  row,
    output logic [SLOT_W-1:0] off,
    output logic              frame_end
);
    logic [COL_W-1:0]  col_q;
    logic [ROW_W-1:0]  row_q;
    logic [SLOT_W-1:0] off_q;
    logic              last_col, last_row, off_wrap;

    // Flag the row end, the frame end and the offset wrap.
    always_comb begin
        last_col  = (col_q == cfg_cols - COL_W'(1));
        last_row  = (row_q == cfg_rows - ROW_W'(1));
        frame_end = last_col && last_row;
        off_wrap  = frame_end || ((off_q + SLOT_W'(1)) >= cfg_interval);
    end

    // Step the slot position once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
            off_q <= '0;
        end else begin
            col_q <= last_col ? '0 : col_q + COL_W'(1);
            if (last_col) row_q <= last_row ? '0 : row_q + ROW_W'(1);
            off_q <= off_wrap ? '0 : off_q + SLOT_W'(1);
        end
    end

    assign col = col_q;
    assign row = row_q;
    assign off = off_q;

    // R3: a non-zero column is always one more than the column of the previous slot.
    assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q != '0) |-> (col_q == COL_W'($past(col_q) + COL_W'(1))));
endmodule

// File: rtl/fwm_window.sv
// Decides whether a slot is in the window, counts window slots per frame, and marks the padding tail.
// Assumes: the census of the previous frame applies to the current one, so settings only change in reset.
module fwm_window
    import fwm_pkg::*;
#(
    parameter int COL_W  = 5,
    parameter int SLOT_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  cfg_cols,
    input  logic [COL_W-1:0]  cfg_start,
    input  logic [COL_W-1:0]  cfg_stop,
    input  logic [COL_W-1:0]  cfg_wordlen,
    input  logic [COL_W-1:0]  col,
    input  logic [SLOT_W-1:0] off,
    input  logic              frame_end,
    input  logic              slot_rx,
    output slot_kind_e        kind,
    output logic              cfg_bad
);
    logic [SLOT_W-1:0] cnt_q, total_q, data_limit, rel;
    logic              known_q, hit, pad;

    // Classify the current slot.
    always_comb begin
        cfg_bad    = (cfg_start == '0) || (cfg_stop < cfg_start) || (cfg_stop >= cfg_cols);
        rel        = off - SLOT_W'(cfg_start);
        hit        = !cfg_bad && (col != '0) && (off >= SLOT_W'(cfg_start))
                     && (off <= SLOT_W'(cfg_stop)) && (rel < SLOT_W'(cfg_wordlen));
        data_limit = {total_q[SLOT_W-1:3], 3'b000};
        pad        = hit && (!known_q || (cnt_q >= data_limit));
        if (!hit)         kind = SLOT_OFF;
        else if (pad)     kind = SLOT_PAD;
        else if (slot_rx) kind = SLOT_RX;
        else              kind = SLOT_TX;
    end

    // Count window slots in each frame and keep the last total.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            total_q <= '0;
            known_q <= 1'b0;
        end else if (frame_end) begin
            total_q <= cnt_q + SLOT_W'(hit);
            cnt_q   <= '0;
            known_q <= 1'b1;
        end else if (hit) begin
            cnt_q <= cnt_q + SLOT_W'(1);
        end
    end

    // R7: before the first census there are no data slots.
    assert_first_frame_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !known_q |-> (kind == SLOT_OFF || kind == SLOT_PAD));
    // R6: a data slot always lies inside the census of the previous frame.
    assert_data_in_census_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SLOT_TX || kind == SLOT_RX) |-> (cnt_q < total_q));
endmodule

// File: rtl/fwm_bitmux.sv
// Moves transmit bytes onto the bus MSB first and builds receive bytes from the bus.
// Assumes: tx_byte is valid in any cycle where tx_req is high.
module fwm_bitmux
    import fwm_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_kind_e        kind,
    input  logic              slot_rx,
    input  logic              bus_din,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_req,
    output logic              bus_dout,
    output logic              bus_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid
);
    logic [CNT_W-1:0]  tx_cnt_q, rx_cnt_q;
    logic [BYTE_W-2:0] tx_sh_q, rx_sh_q;
    logic [BYTE_W-1:0] rx_byte_q;
    logic              rx_valid_q, tx_slot, rx_slot, tx_first, rx_last;

    // Pick the bus bit and the drive enable for this slot.
    always_comb begin
        tx_slot  = (kind == SLOT_TX);
        rx_slot  = (kind == SLOT_RX);
        tx_first = (tx_cnt_q == '0);
        rx_last  = (rx_cnt_q == CNT_W'(BYTE_W - 1));
        tx_req   = tx_slot && tx_first;
        bus_dout = tx_slot && (tx_first ? tx_byte[BYTE_W-1] : tx_sh_q[BYTE_W-2]);
        bus_oe   = tx_slot || (kind == SLOT_PAD && !slot_rx);
    end

    // Step the transmit shifter on each transmit data slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cnt_q <= '0;
            tx_sh_q  <= '0;
        end else if (tx_slot) begin
            tx_cnt_q <= (tx_cnt_q == CNT_W'(BYTE_W - 1)) ? '0 : tx_cnt_q + CNT_W'(1);
            tx_sh_q  <= tx_first ? tx_byte[BYTE_W-2:0] : {tx_sh_q[BYTE_W-3:0], 1'b0};
        end
    end

    // Shift receive bits in and present each full byte for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_cnt_q   <= '0;
            rx_sh_q    <= '0;
            rx_byte_q  <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            rx_valid_q <= rx_slot && rx_last;
            if (rx_slot) begin
                rx_cnt_q <= rx_last ? '0 : rx_cnt_q + CNT_W'(1);
                rx_sh_q  <= {rx_sh_q[BYTE_W-3:0], bus_din};
                if (rx_last) rx_byte_q <= {rx_sh_q, bus_din};
            end
        end
    end

    assign rx_byte  = rx_byte_q;
    assign rx_valid = rx_valid_q;

    // R4: a byte is only taken in a slot that the block drives.
    assert_req_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> bus_oe);
    // R6: padding takes no byte and drives only zero.
    assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SLOT_PAD) |-> (!tx_req && !bus_dout));
    // R8: a receive strobe lasts a single cycle.
    assert_rx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R8: slots owned by the far end are never driven.
    assert_rx_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_rx |-> !bus_oe);
endmodule

// File: rtl/frame_window_mapper.sv
// Top level: maps a byte stream into and out of the bulk window of a row/column frame.
// Assumes: settings are held stable from reset on; column 0 carries the command channel.
module frame_window_mapper
    import fwm_pkg::*;
#(
    parameter int COL_W   = 5,
    parameter int ROW_W   = 6,
    localparam int SLOT_W = COL_W + ROW_W,
    localparam int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COL_W-1:0]  cfg_cols,
    input  logic [ROW_W-1:0]  cfg_rows,
    input  logic [COL_W-1:0]  cfg_start,
    input  logic [COL_W-1:0]  cfg_stop,
    input  logic [SLOT_W-1:0] cfg_interval,
    input  logic [COL_W-1:0]  cfg_wordlen,
    input  logic              slot_rx,
    input  logic              bus_din,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_req,
    output logic              bus_dout,
    output logic              bus_oe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              win_active,
    output logic              win_pad,
    output logic              config_error
);
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [SLOT_W-1:0] off;
    logic              frame_end;
    slot_kind_e        kind;

    fwm_position #(.COL_W(COL_W), .ROW_W(ROW_W), .SLOT_W(SLOT_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
        .cfg_interval(cfg_interval), .col(col), .row(row), .off(off),
        .frame_end(frame_end)
    );

    fwm_window #(.COL_W(COL_W), .SLOT_W(SLOT_W)) u_win (
        .clk(clk), .rst_n(rst_n), .cfg_cols(cfg_cols), .cfg_start(cfg_start),
        .cfg_stop(cfg_stop), .cfg_wordlen(cfg_wordlen), .col(col), .off(off),
        .frame_end(frame_end), .slot_rx(slot_rx), .kind(kind), .cfg_bad(config_error)
    );

    fwm_bitmux #(.BYTE_W(BYTE_W)) u_bits (
        .clk(clk), .rst_n(rst_n), .kind(kind), .slot_rx(slot_rx), .bus_din(bus_din),
        .tx_byte(tx_byte), .tx_req(tx_req), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    // Report the window flags from the slot classification.
    always_comb begin
        win_active = (kind != SLOT_OFF);
        win_pad    = (kind == SLOT_PAD);
    end

    // R1: the command column is never driven or claimed.
    assert_col0_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (col == '0) |-> (!bus_oe && !win_active));
    // R2: bad settings keep the window closed.
    assert_cfg_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> (!win_active && !tx_req && !bus_oe));
    // R9: row stays in range after reset.
    assert_row_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (row < cfg_rows) || config_error);
endmodule

// File: tb/frame_window_mapper_tb.sv
`timescale 1ns/1ps
module frame_window_mapper_tb;
    localparam int COL_W = 5;
    localparam int ROW_W = 6;
    localparam int SLOT_W = COL_W + ROW_W;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic [COL_W-1:0] cfg_cols, cfg_start, cfg_stop, cfg_wordlen;
    logic [ROW_W-1:0] cfg_rows;
    logic [SLOT_W-1:0] cfg_interval;
    logic slot_rx = 1'b0, bus_din = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic tx_req, bus_dout, bus_oe, rx_valid, win_active, win_pad, config_error;
    logic [7:0] rx_byte;

    int n_cols, n_rows, c_start, c_stop, c_int, c_wl, rx_mode;
    assign cfg_cols     = COL_W'(n_cols);
    assign cfg_rows     = ROW_W'(n_rows);
    assign cfg_start    = COL_W'(c_start);
    assign cfg_stop     = COL_W'(c_stop);
    assign cfg_interval = SLOT_W'(c_int);
    assign cfg_wordlen  = COL_W'(c_wl);

    frame_window_mapper #(.COL_W(COL_W), .ROW_W(ROW_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
        .cfg_start(cfg_start), .cfg_stop(cfg_stop), .cfg_interval(cfg_interval),
        .cfg_wordlen(cfg_wordlen), .slot_rx(slot_rx), .bus_din(bus_din),
        .tx_byte(tx_byte), .tx_req(tx_req), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .win_active(win_active),
        .win_pad(win_pad), .config_error(config_error)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Reference model state
    int m_col, m_row, m_off, m_cnt, m_total, m_rxb, tx_sent, last_tx_row, seed;
    bit m_known, m_rxv;
    bit txq[$];
    bit rxq[$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (row %0d col %0d)", req, act, exp, m_row, m_col);
        end
    endtask

    function automatic bit rx_dir(input int r, input int c);
        case (rx_mode)
            1: return bit'(r % 2);
            2: return bit'((r + c) % 2);
            3: return (c == 3);
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_reset();
        m_col = 0; m_row = 0; m_off = 0; m_cnt = 0; m_total = 0; m_rxb = 0;
        tx_sent = 0; last_tx_row = -1; m_known = 0; m_rxv = 0;
        txq.delete(); rxq.delete();
    endtask

    // Enters with the clock low: applies inputs, compares, advances the model, waits for the next low phase.
    task automatic step();
        bit err, hit, pad, data, e_req, e_oe, e_dout, mid, fend;
        int lim;
        slot_rx = rx_dir(m_row, m_col);
        seed = seed * 1103515245 + 12345;
        bus_din = seed[16];
        tx_byte = 8'(tx_sent * 29 + 90);
        #1;
        err  = (c_start == 0) || (c_stop < c_start) || (c_stop >= n_cols);
        hit  = !err && m_col != 0 && m_off >= c_start && m_off <= c_stop && (m_off - c_start) < c_wl;
        lim  = (m_total / 8) * 8;
        pad  = hit && (!m_known || m_cnt >= lim);
        data = hit && !pad;
        e_req = 0; e_dout = 0; mid = 0;
        e_oe = hit && !slot_rx;
        if (data && !slot_rx) begin
            if (txq.size() == 0) begin
                e_req = 1;
                for (int b = 7; b >= 0; b--) txq.push_back(tx_byte[b]);
                tx_sent++;
            end else mid = 1;
            e_dout = txq.pop_front();
        end
        chk(config_error == err, "R2", config_error, err);
        chk(win_active == hit, "R3", win_active, hit);
        chk(win_pad == pad, "R6", win_pad, pad);
        if (m_col == 0) chk(!bus_oe && !win_active, "R1", bus_oe | win_active, 0);
        if (!m_known && hit) chk(win_pad == 1'b1, "R7", win_pad, 1);
        chk(bus_oe == e_oe, "R8", bus_oe, e_oe);
        chk(tx_req == e_req, "R4", tx_req, e_req);
        if (e_oe) begin
            if (pad) chk(bus_dout == 1'b0, "R6", bus_dout, 0);
            else if (mid && m_row != last_tx_row) chk(bus_dout == e_dout, "R5", bus_dout, e_dout);
            else chk(bus_dout == e_dout, "R4", bus_dout, e_dout);
        end
        if (data && slot_rx) chk(tx_req == 1'b0, "R10", tx_req, 0);
        chk(rx_valid == m_rxv, "R8", rx_valid, m_rxv);
        if (m_rxv) chk(rx_byte == 8'(m_rxb), "R8", rx_byte, m_rxb);
        if (data && !slot_rx) last_tx_row = m_row;
        // advance model
        m_rxv = 0;
        if (data && slot_rx) begin
            rxq.push_back(bus_din);
            if (rxq.size() == 8) begin
                m_rxb = 0;
                foreach (rxq[i]) m_rxb = m_rxb * 2 + int'(rxq[i]);
                m_rxv = 1;
                rxq.delete();
            end
        end
        fend = (m_col == n_cols - 1) && (m_row == n_rows - 1);
        if (fend) begin
            m_total = m_cnt + int'(hit); m_cnt = 0; m_known = 1;
        end else if (hit) m_cnt++;
        m_off = (fend || m_off + 1 >= c_int) ? 0 : m_off + 1;
        if (m_col == n_cols - 1) begin
            m_col = 0;
            m_row = (m_row == n_rows - 1) ? 0 : m_row + 1;
        end else m_col++;
        @(negedge clk);
    endtask

    task automatic run(input int nc, input int nr, input int st, input int sp,
                       input int iv, input int wl, input int mode, input int frames);
        @(negedge clk);
        n_cols = nc; n_rows = nr; c_start = st; c_stop = sp; c_int = iv; c_wl = wl; rx_mode = mode;
        rst_n = 1'b0; slot_rx = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;
        // R9: reset state at the ports
        chk(!bus_oe && !tx_req && !rx_valid && !win_active && !win_pad, "R9",
            {bus_oe, tx_req, rx_valid, win_active, win_pad}, 0);
        rst_n = 1'b1;
        model_reset();
        repeat (frames * nc * nr) step();
    endtask

    initial begin
        seed = 7;
        n_cols = 8; n_rows = 4; c_start = 1; c_stop = 7; c_int = 8; c_wl = 7; rx_mode = 0;
        run(8, 4, 1, 7, 8, 7, 0, 4);     // full frame, transmit only, 28 slots -> 24 data + 4 pad
        run(8, 4, 1, 7, 8, 7, 1, 4);     // full frame, odd rows received
        run(6, 5, 2, 4, 6, 2, 2, 4);     // narrow window, checkerboard direction
        run(8, 3, 1, 3, 5, 3, 3, 5);     // interval shorter than a row
        run(9, 5, 1, 8, 9, 8, 2, 3);     // wider full frame, mixed directions
        run(8, 2, 0, 5, 8, 5, 0, 2);     // R2: start column 0
        run(8, 2, 4, 2, 8, 3, 0, 2);     // R2: stop below start
        run(8, 2, 1, 8, 8, 7, 0, 2);     // R2: stop at column count
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule